// File: doc/BRIEF.md
# Packed Pixel Unpacker

This block sits between a frame word queue and a panel timing stage. It accepts 32-bit memory words through a valid/ready handshake and, for each pixel clock enable, hands out one pixel. Low depths of 1, 2, 4 and 8 bits give a palette index, which an external lookup turns into a color. The 16-bit depth gives two color pixels per word, packed either 5-6-5 or 5-5-5. The widest depth stores one color pixel per word, with 8-bit or 6-bit channels. Color fields narrower than the 8-bit panel channel are widened by repeating their top bits into the low bits.

Two control inputs set how a word is traversed. The first picks whether the pixel in the least significant position or the one in the most significant position leaves first. The second reverses the byte order of the word before any pixel is taken from it. All format controls are captured when a word is accepted, so software may change them while a word is still being emitted without disturbing it.

The controller has two named states. `ST_LOAD` waits for a word with `in_ready` high. The transition *accept* (`in_valid` high in `ST_LOAD`) captures the word and its format and moves to `ST_EMIT`. In `ST_EMIT` each `pix_en` emits one pixel (transition *step*). The step that emits the final pixel of the word is the transition *drain*, and it returns to `ST_LOAD`.

Top module: `pixel_unpacker`

## Requirements
- R1: After reset `in_ready` is 1, `pix_valid` is 0, and `pix_is_index`, `pix_index`, `pix_r`, `pix_g` and `pix_b` are all 0.
- R2: A word is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until the edge that emits the word's last pixel. It is 1 in the cycle after that edge.
- R3: The number of pixels per word is 32, 16, 8 or 4 for `cfg_depth` 0, 1, 2 or 3 (1, 2, 4 or 8 bits per pixel), 2 for `cfg_depth` 4, and 1 for `cfg_depth` 5, 6 or 7.
- R4: For `cfg_depth` 0 to 3 with b bits per pixel, pixel k (k from 0) is word bits [k*b+b-1 : k*b] when `cfg_msb_first` is 0, and the field at position n-1-k when it is 1, where n is the pixel count. The field is output zero-extended on `pix_index` with `pix_is_index`=1 and `pix_r`/`pix_g`/`pix_b` = 0.
- R5: For `cfg_depth` 4 with `cfg_555`=0, each 16-bit half has red [15:11], green [10:5] and blue [4:0]. Red and blue widen as {f, f[4:2]} and green as {f, f[5:4]}. `pix_index`=0 and `pix_is_index`=0. The low half is emitted first unless `cfg_msb_first` is 1.
- R6: For `cfg_depth` 4 with `cfg_555`=1, each half has red [14:10], green [9:5] and blue [4:0], each widened as {f, f[4:2]}. Bit 15 of the half has no effect.
- R7: For `cfg_depth` 5 to 7 with `cfg_666`=0, red is word bits [23:16], green [15:8] and blue [7:0], passed unchanged. Bits [31:24] have no effect.
- R8: For `cfg_depth` 5 to 7 with `cfg_666`=1, red is [21:16], green [13:8] and blue [5:0], each widened as {f, f[5:4]}. All other bits have no effect.
- R9: With `cfg_byte_swap`=1, byte i of the word (bits [8i+7:8i]) is moved to byte 3-i before any pixel is taken.
- R10: Each `pix_en` while a word is held emits exactly one pixel. `pix_valid` is 1 in the cycle after that enable edge and 0 otherwise. A `pix_en` with no word held (`in_ready`=1) emits nothing and leaves the pixel outputs unchanged. The pixel outputs hold their value between emissions.
- R11: All `cfg_*` inputs are sampled only on the accept edge. Changing them while a word is being emitted has no effect on that word's pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Memory word offered |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 32 | Memory word |
| cfg_depth | input | 3 | Depth code: 0-3 give 1/2/4/8 bpp index, 4 gives 16-bit color, 5-7 give one color pixel per word |
| cfg_555 | input | 1 | Depth 4: 5-5-5 packing instead of 5-6-5 |
| cfg_666 | input | 1 | Depth 5-7: 6-bit channels instead of 8-bit |
| cfg_msb_first | input | 1 | Emit the most significant pixel of a word first |
| cfg_byte_swap | input | 1 | Reverse byte order of the word |
| pix_en | input | 1 | Pixel clock enable |
| pix_valid | output | 1 | Pixel outputs updated by the last enable |
| pix_is_index | output | 1 | Pixel is a palette index |
| pix_index | output | 8 | Palette index |
| pix_r | output | 8 | Red channel |
| pix_g | output | 8 | Green channel |
| pix_b | output | 8 | Blue channel |

## Verification
If the remaining-pixel count is wrong, `in_ready` returns one or more enables early or late. That shows on the edge where the word's last pixel should leave. If the shift register or the captured order flag is wrong, the second pixel of the word already carries the wrong field. If the captured format is wrong, the first `pix_valid` after the accept shows a wrong channel split or a wrong `pix_is_index`. Format controls are scrambled during every emission, so any leak of live configuration into a word in flight shows up on the next emitted pixel.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
    parameter int WORD_W = 32;
    parameter int CH_W   = 8;
    parameter int IDX_W  = 8;

    typedef enum logic [2:0] {
        FMT_INDEX,
        FMT_565,
        FMT_555,
        FMT_888,
        FMT_666
    } pxu_fmt_e;
endpackage

// File: rtl/pxu_ctrl.sv
module pxu_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic pix_en,
    input  logic last_pix,
    output logic in_ready,
    output logic load,
    output logic step
);
    typedef enum logic {ST_LOAD, ST_EMIT} st_e;
    st_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_LOAD;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d     = st_q;
        in_ready = 1'b0;
        load     = 1'b0;
        step     = 1'b0;
        unique case (st_q)
            ST_LOAD: begin
                in_ready = 1'b1;
                load     = in_valid;
                if (in_valid) st_d = ST_EMIT;
            end
            ST_EMIT: begin
                step = pix_en;
                if (pix_en && last_pix) st_d = ST_LOAD;
            end
        endcase
    end
endmodule

// File: rtl/pxu_shift.sv
module pxu_shift
    import pxu_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   in_word,
    input  logic [2:0]     cfg_depth,
    input  logic           cfg_555,
    input  logic           cfg_666,
    input  logic           cfg_msb_first,
    input  logic           cfg_byte_swap,
    output logic [W-1:0]   cur_raw,
    output pxu_fmt_e       cur_fmt,
    output logic           last_pix
);
    localparam int NB    = W / 8;
    localparam int CNT_W = $clog2(W) + 1;
    localparam logic [W-1:0] ONE_W = 1;

    logic [W-1:0]     swapped;
    logic [W-1:0]     word_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] bits_q;
    logic             msb_q;
    pxu_fmt_e         fmt_q;
    logic [2:0]       lg_in;
    pxu_fmt_e         fmt_in;

    for (genvar i = 0; i < NB; i++) begin : g_swap
        assign swapped[i*8 +: 8] = in_word[(NB-1-i)*8 +: 8];
    end

    always_comb begin
        if (cfg_depth <= 3'd3)      lg_in = cfg_depth;
        else if (cfg_depth == 3'd4) lg_in = 3'd4;
        else                        lg_in = 3'd5;

        if (cfg_depth <= 3'd3)      fmt_in = FMT_INDEX;
        else if (cfg_depth == 3'd4) fmt_in = cfg_555 ? FMT_555 : FMT_565;
        else                        fmt_in = cfg_666 ? FMT_666 : FMT_888;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            cnt_q  <= '0;
            bits_q <= '0;
            msb_q  <= 1'b0;
            fmt_q  <= FMT_INDEX;
        end else if (load) begin
            word_q <= cfg_byte_swap ? swapped : in_word;
            cnt_q  <= CNT_W'(W >> lg_in);
            bits_q <= CNT_W'(1) << lg_in;
            msb_q  <= cfg_msb_first;
            fmt_q  <= fmt_in;
        end else if (step) begin
            word_q <= msb_q ? (word_q << bits_q) : (word_q >> bits_q);
            cnt_q  <= cnt_q - CNT_W'(1);
        end
    end

    always_comb begin
        if (msb_q) cur_raw = word_q >> (CNT_W'(W) - bits_q);
        else       cur_raw = word_q & ((ONE_W << bits_q) - ONE_W);
    end

    assign cur_fmt  = fmt_q;
    assign last_pix = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/pxu_fmt.sv
module pxu_fmt
    import pxu_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int CW = CH_W,
    parameter int IW = IDX_W
) (
    input  logic [W-1:0]  raw,
    input  pxu_fmt_e      fmt,
    output logic          is_index,
    output logic [IW-1:0] index,
    output logic [CW-1:0] r,
    output logic [CW-1:0] g,
    output logic [CW-1:0] b
);
    localparam int REP = $clog2(CW) + 1;

    function automatic logic [CW-1:0] widen(input logic [7:0] f, input int w);
        logic [CW-1:0] o;
        o = CW'(f) << (CW - w);
        for (int j = 0; j < REP; j++) o = o | (o >> (w << j));
        return o;
    endfunction

    always_comb begin
        is_index = 1'b0;
        index    = '0;
        r        = '0;
        g        = '0;
        b        = '0;
        unique case (fmt)
            FMT_INDEX: begin
                is_index = 1'b1;
                index    = raw[IW-1:0];
            end
            FMT_565: begin
                r = widen({3'b0, raw[15:11]}, 5);
                g = widen({2'b0, raw[10:5]}, 6);
                b = widen({3'b0, raw[4:0]}, 5);
            end
            FMT_555: begin
                r = widen({3'b0, raw[14:10]}, 5);
                g = widen({3'b0, raw[9:5]}, 5);
                b = widen({3'b0, raw[4:0]}, 5);
            end
            FMT_888: begin
                r = widen(raw[23:16], 8);
                g = widen(raw[15:8], 8);
                b = widen(raw[7:0], 8);
            end
            FMT_666: begin
                r = widen({2'b0, raw[21:16]}, 6);
                g = widen({2'b0, raw[13:8]}, 6);
                b = widen({2'b0, raw[5:0]}, 6);
            end
        endcase
    end
endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
    import pxu_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int CW = CH_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [W-1:0]  in_word,
    input  logic [2:0]    cfg_depth,
    input  logic          cfg_555,
    input  logic          cfg_666,
    input  logic          cfg_msb_first,
    input  logic          cfg_byte_swap,
    input  logic          pix_en,
    output logic          pix_valid,
    output logic          pix_is_index,
    output logic [IW-1:0] pix_index,
    output logic [CW-1:0] pix_r,
    output logic [CW-1:0] pix_g,
    output logic [CW-1:0] pix_b
);
    logic          load, step, last_pix;
    logic [W-1:0]  cur_raw;
    pxu_fmt_e      cur_fmt;
    logic          f_is_index;
    logic [IW-1:0] f_index;
    logic [CW-1:0] f_r, f_g, f_b;

    pxu_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .pix_en   (pix_en),
        .last_pix (last_pix),
        .in_ready (in_ready),
        .load     (load),
        .step     (step)
    );

    pxu_shift #(.W(W)) u_shift (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (load),
        .step          (step),
        .in_word       (in_word),
        .cfg_depth     (cfg_depth),
        .cfg_555       (cfg_555),
        .cfg_666       (cfg_666),
        .cfg_msb_first (cfg_msb_first),
        .cfg_byte_swap (cfg_byte_swap),
        .cur_raw       (cur_raw),
        .cur_fmt       (cur_fmt),
        .last_pix      (last_pix)
    );

    pxu_fmt #(.W(W), .CW(CW), .IW(IW)) u_fmt (
        .raw      (cur_raw),
        .fmt      (cur_fmt),
        .is_index (f_is_index),
        .index    (f_index),
        .r        (f_r),
        .g        (f_g),
        .b        (f_b)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid    <= 1'b0;
            pix_is_index <= 1'b0;
            pix_index    <= '0;
            pix_r        <= '0;
            pix_g        <= '0;
            pix_b        <= '0;
        end else begin
            pix_valid <= step;
            if (step) begin
                pix_is_index <= f_is_index;
                pix_index    <= f_index;
                pix_r        <= f_r;
                pix_g        <= f_g;
                pix_b        <= f_b;
            end
        end
    end
endmodule

// File: rtl/pixel_unpacker_chk.sv
module pixel_unpacker_chk #(
    parameter int CW = 8,
    parameter int IW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          pix_en,
    input logic          pix_valid,
    input logic          pix_is_index,
    input logic [IW-1:0] pix_index,
    input logic [CW-1:0] pix_r,
    input logic [CW-1:0] pix_g,
    input logic [CW-1:0] pix_b
);
    a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    a_r2_ready_waits_for_word: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> in_ready);

    a_r10_valid_follows_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_en) |=> !pix_valid);

    a_r10_no_pixel_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && pix_en) |=> !pix_valid);

    a_r10_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_en) |=> ($stable(pix_index) && $stable(pix_r) && $stable(pix_g)
                       && $stable(pix_b) && $stable(pix_is_index)));

    a_r4_index_has_no_color: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_is_index) |-> (pix_r == '0 && pix_g == '0 && pix_b == '0));
endmodule

bind pixel_unpacker pixel_unpacker_chk #(.CW(CW), .IW(IW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .pix_en       (pix_en),
    .pix_valid    (pix_valid),
    .pix_is_index (pix_is_index),
    .pix_index    (pix_index),
    .pix_r        (pix_r),
    .pix_g        (pix_g),
    .pix_b        (pix_b)
);

// File: tb/pixel_unpacker_bench.sv
module pixel_unpacker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic [2:0]  cfg_depth = '0;
    logic        cfg_555 = 1'b0, cfg_666 = 1'b0, cfg_msb_first = 1'b0, cfg_byte_swap = 1'b0;
    logic        pix_en = 1'b0;
    logic        pix_valid, pix_is_index;
    logic [7:0]  pix_index, pix_r, pix_g, pix_b;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pixel_unpacker u_pixel_unpacker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .cfg_depth(cfg_depth), .cfg_555(cfg_555), .cfg_666(cfg_666),
        .cfg_msb_first(cfg_msb_first), .cfg_byte_swap(cfg_byte_swap), .pix_en(pix_en),
        .pix_valid(pix_valid), .pix_is_index(pix_is_index), .pix_index(pix_index),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int npix(input logic [2:0] code);
        if (code <= 3) return 32 >> code;
        if (code == 4) return 2;
        return 1;
    endfunction

    function automatic logic [7:0] w5(input logic [4:0] f); return {f, f[4:2]}; endfunction
    function automatic logic [7:0] w6(input logic [5:0] f); return {f, f[5:4]}; endfunction

    // {is_index, index, r, g, b}
    function automatic logic [32:0] expect_pix(input logic [31:0] w, input logic [2:0] code,
            input bit f555, input bit f666, input bit msb, input bit swp, input int k);
        int bpp, n, pos;
        logic [31:0] fld;
        if (swp) w = {w[7:0], w[15:8], w[23:16], w[31:24]};
        n   = npix(code);
        bpp = 32 / n;
        pos = msb ? (n - 1 - k) * bpp : k * bpp;
        fld = (bpp == 32) ? w : ((w >> pos) & ((32'd1 << bpp) - 1));
        if (code <= 3) return {1'b1, fld[7:0], 24'h0};
        if (code == 4) begin
            if (f555) return {1'b0, 8'h0, w5(fld[14:10]), w5(fld[9:5]), w5(fld[4:0])};
            return {1'b0, 8'h0, w5(fld[15:11]), w6(fld[10:5]), w5(fld[4:0])};
        end
        if (f666) return {1'b0, 8'h0, w6(fld[21:16]), w6(fld[13:8]), w6(fld[5:0])};
        return {1'b0, 8'h0, fld[23:16], fld[15:8], fld[7:0]};
    endfunction

    function automatic string tag_of(input logic [2:0] code, input bit f555, input bit f666, input bit swp);
        string t;
        if (code <= 3)      t = "R4";
        else if (code == 4) t = f555 ? "R6" : "R5";
        else                t = f666 ? "R8" : "R7";
        if (swp) t = {t, "/R9"};
        return {t, "/R11"};
    endfunction

    task automatic run_word(input logic [31:0] w, input logic [2:0] code, input bit f555,
            input bit f666, input bit msb, input bit swp, input int gap);
        int n;
        logic [32:0] e;
        logic [32:0] a;
        string t;
        n = npix(code);
        t = tag_of(code, f555, f666, swp);
        @(negedge clk);
        chk(in_ready === 1'b1, "R2 ready before word", {63'b0, in_ready}, 64'd1);
        in_word = w; cfg_depth = code; cfg_555 = f555; cfg_666 = f666;
        cfg_msb_first = msb; cfg_byte_swap = swp; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_word = $urandom;
        {cfg_depth, cfg_555, cfg_666, cfg_msb_first, cfg_byte_swap} = 7'($urandom);
        chk(in_ready === 1'b0, "R2 ready low after accept", {63'b0, in_ready}, 64'd0);
        for (int k = 0; k < n; k++) begin
            for (int g = 0; g < gap; g++) begin
                pix_en = 1'b0;
                @(negedge clk);
                chk(pix_valid === 1'b0, "R10 no valid without enable", {63'b0, pix_valid}, 64'd0);
            end
            pix_en = 1'b1;
            @(negedge clk);
            pix_en = 1'b0;
            {cfg_depth, cfg_555, cfg_666, cfg_msb_first, cfg_byte_swap} = 7'($urandom);
            e = expect_pix(w, code, f555, f666, msb, swp, k);
            a = {pix_is_index, pix_index, pix_r, pix_g, pix_b};
            chk(pix_valid === 1'b1, "R10 valid after enable", {63'b0, pix_valid}, 64'd1);
            chk(a === e, t, {31'b0, a}, {31'b0, e});
            chk(in_ready === (k == n - 1), "R3 pixel count / R2 ready return",
                {63'b0, in_ready}, {63'b0, (k == n - 1)});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] keep;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(in_ready === 1'b1, "R1 ready", {63'b0, in_ready}, 64'd1);
        chk(pix_valid === 1'b0, "R1 valid", {63'b0, pix_valid}, 64'd0);
        chk({pix_is_index, pix_index, pix_r, pix_g, pix_b} === 33'd0, "R1 pixel outputs",
            {31'b0, pix_is_index, pix_index, pix_r, pix_g, pix_b}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corner cases
        run_word(32'h12345678, 3'd3, 0, 0, 0, 0, 0);
        chk(pix_index === 8'h12, "R4 last lsb-first byte", {56'b0, pix_index}, 64'h12);
        run_word(32'h12345678, 3'd3, 0, 0, 1, 0, 1);
        chk(pix_index === 8'h78, "R4 last msb-first byte", {56'b0, pix_index}, 64'h78);
        run_word(32'h80000001, 3'd0, 0, 0, 0, 0, 0);
        run_word(32'hC0000003, 3'd1, 0, 0, 1, 0, 0);
        run_word(32'hF0A5_0F5A, 3'd2, 0, 0, 0, 0, 0);
        run_word(32'hFFFF_0000, 3'd4, 0, 0, 0, 0, 0);
        chk({pix_r, pix_g, pix_b} === 24'hFFFFFF, "R5 white widens to full",
            {40'b0, pix_r, pix_g, pix_b}, 64'hFFFFFF);
        run_word(32'hF800_07E0, 3'd4, 0, 0, 1, 0, 2);
        run_word(32'h8000_FFFF, 3'd4, 1, 0, 0, 0, 0);
        chk({pix_r, pix_g, pix_b} === 24'h0, "R6 bit 15 ignored",
            {40'b0, pix_r, pix_g, pix_b}, 64'h0);
        run_word(32'hAB112233, 3'd5, 0, 0, 0, 0, 0);
        chk({pix_r, pix_g, pix_b} === 24'h112233, "R7 top byte ignored",
            {40'b0, pix_r, pix_g, pix_b}, 64'h112233);
        run_word(32'hFFC0C0C0, 3'd5, 0, 1, 0, 0, 0);
        chk({pix_r, pix_g, pix_b} === 24'h0, "R8 unused bits ignored",
            {40'b0, pix_r, pix_g, pix_b}, 64'h0);
        run_word(32'h00FF3F2A, 3'd5, 0, 1, 0, 0, 0);
        run_word(32'h00102030, 3'd6, 0, 0, 0, 0, 0);
        run_word(32'h00102030, 3'd7, 0, 0, 0, 1, 0);
        chk({pix_r, pix_g, pix_b} === 24'h201000, "R9 byte swap",
            {40'b0, pix_r, pix_g, pix_b}, 64'h201000);
        run_word(32'h01020304, 3'd3, 0, 0, 0, 1, 0);

        // R10: enable with no word held
        @(negedge clk);
        keep = pix_b;
        pix_en = 1'b1;
        @(negedge clk);
        pix_en = 1'b0;
        chk(pix_valid === 1'b0, "R10 no pixel when empty", {63'b0, pix_valid}, 64'd0);
        chk(pix_b === keep, "R10 outputs held when empty", {56'b0, pix_b}, {56'b0, keep});

        // constrained random
        for (int i = 0; i < 80; i++) begin
            logic [2:0] c;
            c = 3'($urandom_range(0, 7));
            run_word($urandom, c, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                     int'($urandom_range(0, 2)));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule